// File: doc/BRIEF.md
# Tiny Four-Register Byte Processor

This block is a small 8-bit processor with four byte registers (A, B, C, D) and a byte-wide instruction pointer. It steps through a fetch, decode and execute loop over a 256-byte memory reached through one synchronous port. The memory returns read data one cycle after a read request, and a write takes effect in the cycle it is requested. An instruction is one opcode byte, optionally followed by one operand byte. Opcodes are grouped by their upper nibble: control flow, register moves, memory and stream transfers, arithmetic and logic, and comparison.

Two byte streams with valid/ready handshakes serve the console instructions. One instruction waits on the input stream for a byte and places it in A. Another offers A on the output stream and waits for it to be accepted. A separate combinational unit produces every arithmetic, logic and comparison result, and the result always lands in A.

The core stops on the halt opcode, on any opcode outside the map, or when sequential advance would carry the instruction pointer beyond the last address. When it stops on an opcode outside the map, it raises a fault flag and exposes the address of that opcode. Only a reset restarts it.

Top module: `t8_core`

## Requirements
- R1: While reset is held, running is 1, halted is 0, fault is 0, and the core requests a read of address 0. After release, execution starts at address 0 with all four registers at zero.
- R2: Opcodes 0x10..0x1F copy a register to a register: bits [3:2] name the destination and bits [1:0] the source, with A=0, B=1, C=2, D=3. When the two fields are equal, the destination is loaded from the operand byte instead, and the instruction is two bytes long.
- R3: Opcodes 0x30..0x3A and 0x40..0x41 write A. The operations are: 0x30/0x31 add, 0x32/0x33 multiply, 0x34/0x35 AND, 0x36/0x37 OR, 0x38 NOT, 0x39/0x3A XOR, 0x41/0x40 compare. For every pair except the compare pair, the first opcode takes the operand byte and the second takes B; for compare, 0x41 takes the operand byte and 0x40 takes B. Add and multiply keep the low 8 bits. Compare gives 0 if A is less, 1 if equal and 2 if greater.
- R4: 0x02 jumps to the operand byte. 0x03, 0x04 and 0x05 jump there only if A is nonzero, A is zero, or A equals 1, respectively. Otherwise they advance by 2.
- R5: 0x06 and 0x07 load the instruction pointer from B. 0x08, 0x09 and 0x0A do so under the same three A tests. Otherwise they advance by 1.
- R6: 0x20 loads A from the address held in the operand byte and 0x21 loads A from address B. 0x22 stores A to the address in the operand byte and 0x23 stores A to address B.
- R7: 0x24 holds in_ready high and makes no other progress until in_valid is seen. It then places in_data in A.
- R8: 0x25 holds out_valid high with out_data equal to A, unchanged, until out_ready is seen.
- R9: Opcode 0x01 stops the core: running drops to 0, halted rises to 1 and fault stays 0.
- R10: An opcode outside the map stops the core with fault at 1, and fault_ip gives that opcode's address.
- R11: A one-byte instruction at address 0xFF completes and then stops the core, unless it is a taken jump. A two-byte instruction at 0xFF stops the core without any effect. Neither case raises fault.
- R12: Once stopped, the core issues no memory read or write and no stream handshake signal, and it stays stopped until reset.
- R13: The memory port never requests a read and a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address |
| mem_re | output | 1 | Read request; data returns next cycle |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| in_valid | input | 1 | Input stream byte available |
| in_data | input | 8 | Input stream byte |
| in_ready | output | 1 | Core waiting for an input byte |
| out_valid | output | 1 | Output stream byte offered |
| out_data | output | 8 | Output stream byte |
| out_ready | input | 1 | Output byte accepted |
| running | output | 1 | Core is executing |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Stopped on an opcode outside the map |
| fault_ip | output | 8 | Address of the faulting opcode |

## Verification
The assertions check the memory port, the stream handshakes and the stopped state on every cycle. They confirm that a read and a write never coincide, that a stopped core stays silent and stopped, that a fault never appears without a stop and keeps its address, and that an offered output byte or a pending input request is held until the other side responds. Only the bench's directed programs can show the data results: the move matrix and its immediate diagonal, each ALU operation and the compare encoding, taken and untaken jumps of every flavour, loads and stores by both addressing forms, and the rules for stopping at the end of memory.

// File: rtl/t8_pkg.sv
package t8_pkg;

    localparam int unsigned WORD_W   = 8;
    localparam int unsigned NUM_REGS = 4;
    localparam int unsigned RIDX_W   = $clog2(NUM_REGS);

    localparam logic [RIDX_W-1:0] REG_A = RIDX_W'(0);
    localparam logic [RIDX_W-1:0] REG_B = RIDX_W'(1);

    typedef enum logic [2:0] {
        ALU_ADD, ALU_MUL, ALU_AND, ALU_OR, ALU_NOT, ALU_XOR, ALU_CMP, ALU_PASS
    } alu_op_e;

    typedef enum logic [3:0] {
        K_NOP, K_STOP, K_JUMP, K_MOVE, K_LOAD, K_STORE,
        K_READ_IN, K_WRITE_OUT, K_ALU, K_BAD
    } kind_e;

    typedef enum logic [1:0] {
        C_ALWAYS, C_NONZERO, C_ZERO, C_ONE
    } cond_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_OPERAND, ST_DATA,
        ST_IN, ST_OUT, ST_COMMIT, ST_HALT
    } state_e;

    typedef struct packed {
        kind_e             kind;
        logic              has_imm;   // instruction carries a second byte
        logic              use_b;     // address, target or operand comes from B
        cond_e             cond;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] src;
        alu_op_e           alu;
    } dec_t;

    function automatic logic cond_met(cond_e c, logic [WORD_W-1:0] a);
        case (c)
            C_ALWAYS:  return 1'b1;
            C_NONZERO: return a != '0;
            C_ZERO:    return a == '0;
            C_ONE:     return a == WORD_W'(1);
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/t8_decode.sv
module t8_decode
    import t8_pkg::*;
(
    input  logic [WORD_W-1:0] opcode,
    output dec_t              dec
);

    logic [3:0] grp;
    logic [3:0] low;

    assign grp = opcode[7:4];
    assign low = opcode[3:0];

    always_comb begin
        dec      = '0;
        dec.kind = K_BAD;
        dec.cond = C_ALWAYS;
        dec.alu  = ALU_PASS;
        case (grp)
            4'h0: begin
                case (low)
                    4'h0: dec.kind = K_NOP;
                    4'h1: dec.kind = K_STOP;
                    4'h2, 4'h3, 4'h4, 4'h5: begin
                        dec.kind    = K_JUMP;
                        dec.has_imm = 1'b1;
                        dec.cond    = (low == 4'h3) ? C_NONZERO :
                                      (low == 4'h4) ? C_ZERO    :
                                      (low == 4'h5) ? C_ONE     : C_ALWAYS;
                    end
                    4'h6, 4'h7, 4'h8, 4'h9, 4'hA: begin
                        dec.kind  = K_JUMP;
                        dec.use_b = 1'b1;
                        dec.cond  = (low == 4'h8) ? C_NONZERO :
                                    (low == 4'h9) ? C_ZERO    :
                                    (low == 4'hA) ? C_ONE     : C_ALWAYS;
                    end
                    default: dec.kind = K_BAD;
                endcase
            end
            4'h1: begin
                dec.kind    = K_MOVE;
                dec.dst     = low[3:2];
                dec.src     = low[1:0];
                dec.has_imm = (low[3:2] == low[1:0]);
            end
            4'h2: begin
                case (low)
                    4'h0: begin dec.kind = K_LOAD;  dec.has_imm = 1'b1; end
                    4'h1: begin dec.kind = K_LOAD;  dec.use_b   = 1'b1; end
                    4'h2: begin dec.kind = K_STORE; dec.has_imm = 1'b1; end
                    4'h3: begin dec.kind = K_STORE; dec.use_b   = 1'b1; end
                    4'h4: dec.kind = K_READ_IN;
                    4'h5: dec.kind = K_WRITE_OUT;
                    default: dec.kind = K_BAD;
                endcase
            end
            4'h3: begin
                if (low <= 4'hA) begin
                    dec.kind = K_ALU;
                    case (low)
                        4'h0, 4'h1: dec.alu = ALU_ADD;
                        4'h2, 4'h3: dec.alu = ALU_MUL;
                        4'h4, 4'h5: dec.alu = ALU_AND;
                        4'h6, 4'h7: dec.alu = ALU_OR;
                        4'h8:       dec.alu = ALU_NOT;
                        default:    dec.alu = ALU_XOR;
                    endcase
                    if (low == 4'h8) begin
                        dec.has_imm = 1'b0;
                        dec.use_b   = 1'b0;
                    end else if (low <= 4'h7) begin
                        dec.has_imm = ~low[0];
                        dec.use_b   = low[0];
                    end else begin
                        dec.has_imm = low[0];
                        dec.use_b   = ~low[0];
                    end
                end
            end
            4'h4: begin
                if (low <= 4'h1) begin
                    dec.kind    = K_ALU;
                    dec.alu     = ALU_CMP;
                    dec.has_imm = low[0];
                    dec.use_b   = ~low[0];
                end
            end
            default: dec.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/t8_alu.sv
module t8_alu
    import t8_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    logic [2*W-1:0] prod;

    assign prod = a * b;

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_MUL: y = prod[W-1:0];
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOT: y = ~a;
            ALU_XOR: y = a ^ b;
            ALU_CMP: y = (a < b) ? W'(0) : ((a == b) ? W'(1) : W'(2));
            default: y = b;
        endcase
    end

endmodule

// File: rtl/t8_regfile.sv
module t8_regfile #(
    parameter int unsigned W = 8,
    parameter int unsigned N = 4,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [IW-1:0]       widx,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] q
);

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else if (we && widx == IW'(g)) begin
                q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/t8_core.sv
module t8_core
    import t8_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    localparam int unsigned ADDR_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              running,
    output logic              halted,
    output logic              fault,
    output logic [ADDR_W-1:0] fault_ip
);

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] ip_q, ip_d;
    logic [DATA_W-1:0] op_q, op_d;
    logic [DATA_W-1:0] arg_q, arg_d;
    logic              fault_q, fault_d;
    logic [ADDR_W-1:0] fault_ip_q, fault_ip_d;

    logic [DATA_W-1:0] cur_op;
    dec_t              dec;

    logic                       rf_we;
    logic [RIDX_W-1:0]          rf_idx;
    logic [DATA_W-1:0]          rf_wdata;
    logic [NUM_REGS-1:0][DATA_W-1:0] rf_q;
    logic [DATA_W-1:0]          a_val, b_val;

    logic [DATA_W-1:0] alu_b, alu_y;
    logic [ADDR_W:0]   seq_ip;
    logic              taken;

    // The opcode is decoded straight off the read port in the decode cycle.
    assign cur_op = (state_q == ST_DECODE) ? mem_rdata : op_q;

    t8_decode u_dec (
        .opcode (cur_op),
        .dec    (dec)
    );

    t8_regfile #(.W(DATA_W), .N(NUM_REGS)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .widx  (rf_idx),
        .wdata (rf_wdata),
        .q     (rf_q)
    );

    assign a_val = rf_q[REG_A];
    assign b_val = rf_q[REG_B];
    assign alu_b = dec.use_b ? b_val : arg_q;

    t8_alu #(.W(DATA_W)) u_alu (
        .op (dec.alu),
        .a  (a_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign seq_ip = {1'b0, ip_q} + {{ADDR_W{1'b0}}, 1'b1} + {{ADDR_W{1'b0}}, dec.has_imm};
    assign taken  = (dec.kind == K_JUMP) && cond_met(dec.cond, a_val);

    always_comb begin
        state_d    = state_q;
        ip_d       = ip_q;
        op_d       = op_q;
        arg_d      = arg_q;
        fault_d    = fault_q;
        fault_ip_d = fault_ip_q;
        mem_addr   = ip_q;
        mem_re     = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = a_val;
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        rf_we      = 1'b0;
        rf_idx     = REG_A;
        rf_wdata   = arg_q;

        case (state_q)
            ST_FETCH: begin
                mem_re  = 1'b1;
                state_d = ST_DECODE;
            end
            ST_DECODE: begin
                op_d = mem_rdata;
                if (dec.kind == K_BAD) begin
                    fault_d    = 1'b1;
                    fault_ip_d = ip_q;
                    state_d    = ST_HALT;
                end else if (dec.kind == K_STOP) begin
                    state_d = ST_HALT;
                end else if (dec.has_imm) begin
                    if (&ip_q) begin
                        state_d = ST_HALT;
                    end else begin
                        mem_addr = ip_q + ADDR_W'(1);
                        mem_re   = 1'b1;
                        state_d  = ST_OPERAND;
                    end
                end else begin
                    case (dec.kind)
                        K_LOAD: begin
                            mem_addr = b_val;
                            mem_re   = 1'b1;
                            state_d  = ST_DATA;
                        end
                        K_STORE: begin
                            mem_addr = b_val;
                            mem_we   = 1'b1;
                            state_d  = ST_COMMIT;
                        end
                        K_READ_IN:   state_d = ST_IN;
                        K_WRITE_OUT: state_d = ST_OUT;
                        default:     state_d = ST_COMMIT;
                    endcase
                end
            end
            ST_OPERAND: begin
                arg_d = mem_rdata;
                case (dec.kind)
                    K_LOAD: begin
                        mem_addr = mem_rdata;
                        mem_re   = 1'b1;
                        state_d  = ST_DATA;
                    end
                    K_STORE: begin
                        mem_addr = mem_rdata;
                        mem_we   = 1'b1;
                        state_d  = ST_COMMIT;
                    end
                    default: state_d = ST_COMMIT;
                endcase
            end
            ST_DATA: begin
                arg_d   = mem_rdata;
                state_d = ST_COMMIT;
            end
            ST_IN: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    arg_d   = in_data;
                    state_d = ST_COMMIT;
                end
            end
            ST_OUT: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    state_d = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                case (dec.kind)
                    K_MOVE: begin
                        rf_we    = 1'b1;
                        rf_idx   = dec.dst;
                        rf_wdata = dec.has_imm ? arg_q : rf_q[dec.src];
                    end
                    K_LOAD, K_READ_IN: begin
                        rf_we    = 1'b1;
                        rf_wdata = arg_q;
                    end
                    K_ALU: begin
                        rf_we    = 1'b1;
                        rf_wdata = alu_y;
                    end
                    default: rf_we = 1'b0;
                endcase
                if (taken) begin
                    ip_d    = dec.use_b ? b_val : arg_q;
                    state_d = ST_FETCH;
                end else if (seq_ip[ADDR_W]) begin
                    state_d = ST_HALT;
                end else begin
                    ip_d    = seq_ip[ADDR_W-1:0];
                    state_d = ST_FETCH;
                end
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_FETCH;
            ip_q       <= '0;
            op_q       <= '0;
            arg_q      <= '0;
            fault_q    <= 1'b0;
            fault_ip_q <= '0;
        end else begin
            state_q    <= state_d;
            ip_q       <= ip_d;
            op_q       <= op_d;
            arg_q      <= arg_d;
            fault_q    <= fault_d;
            fault_ip_q <= fault_ip_d;
        end
    end

    assign out_data = a_val;
    assign running  = (state_q != ST_HALT);
    assign halted   = (state_q == ST_HALT);
    assign fault    = fault_q;
    assign fault_ip = fault_ip_q;

endmodule

// File: rtl/t8_core_chk.sv
module t8_core_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         mem_re,
    input logic         mem_we,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         out_ready,
    input logic         halted,
    input logic         fault,
    input logic [W-1:0] fault_ip
);

    p_single_access_r13: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    p_quiet_when_stopped_r12: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_re && !mem_we && !out_valid && !in_ready));

    p_stop_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_fault_stops_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> halted);

    p_fault_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        fault |=> (fault && $stable(fault_ip)));

    p_out_held_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_in_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> in_ready);

endmodule

bind t8_core t8_core_chk #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .halted    (halted),
    .fault     (fault),
    .fault_ip  (fault_ip)
);

// File: tb/tb_t8_core.sv
module tb_t8_core;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr;
    logic       mem_re, mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;
    logic       running, halted, fault;
    logic [7:0] fault_ip;

    always #(CLK_PERIOD/2) clk = ~clk;

    t8_core dut (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .running(running), .halted(halted), .fault(fault), .fault_ip(fault_ip)
    );

    logic [7:0] mem [256];
    logic [7:0] img [256];
    logic [7:0] code [$];
    logic [7:0] exp_q [$];
    logic [7:0] obuf [64];
    logic [7:0] ibuf [8];
    int icount = 0;
    int in_delay = 0, out_delay = 0;
    int ocnt = 0, iidx = 0, ogap = 0, igap = 0;
    int owait = 0, iwait = 0, hold_err = 0, both_err = 0;
    logic prev_wait = 1'b0;
    logic [7:0] prev_data = 8'h00;
    int checks = 0, errors = 0;

    // memory model: image copied in during reset, one-cycle read latency
    always @(posedge clk) begin
        if (rst) mem <= img;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    // stream partners, driven away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            ocnt = 0; iidx = 0; ogap = 0; igap = 0;
            owait = 0; iwait = 0; hold_err = 0; both_err = 0;
            prev_wait = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        end else begin
            if (prev_wait && (!out_valid || out_data != prev_data)) hold_err++;
            if (out_valid) begin
                if (ogap >= out_delay) begin
                    out_ready = 1'b1;
                    if (ocnt < 64) obuf[ocnt] = out_data;
                    ocnt++;
                    ogap = 0;
                end else begin
                    out_ready = 1'b0;
                    ogap++;
                    owait++;
                end
            end else begin
                out_ready = 1'b0;
            end
            prev_wait = out_valid && !out_ready;
            prev_data = out_data;
            if (in_ready) begin
                if (igap >= in_delay && iidx < icount) begin
                    in_valid = 1'b1;
                    in_data  = ibuf[iidx];
                    iidx++;
                    igap = 0;
                end else begin
                    in_valid = 1'b0;
                    igap++;
                    iwait++;
                end
            end else begin
                in_valid = 1'b0;
            end
            if (mem_re && mem_we) both_err++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
    endtask

    task automatic place(input int base);
        for (int i = 0; i < code.size(); i++) img[(base + i) % 256] = code[i];
    endtask

    task automatic run(input string req, input int limit);
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n = 0;
        while (!halted && n < limit) begin
            @(negedge clk);
            n++;
        end
        check(halted == 1'b1, req, "core stopped within limit", halted, 1);
    endtask

    task automatic expect_out(input string req);
        check(ocnt == exp_q.size(), req, "output byte count", ocnt, exp_q.size());
        for (int i = 0; i < exp_q.size() && i < ocnt; i++)
            check(obuf[i] == exp_q[i], req, $sformatf("output byte %0d", i), obuf[i], exp_q[i]);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(running == 1'b1, "R1", "running in reset", running, 1);
        check(halted == 1'b0, "R1", "halted in reset", halted, 0);
        check(fault == 1'b0, "R1", "fault in reset", fault, 0);
        check(mem_re == 1'b1 && mem_addr == 8'h00, "R1", "first fetch at 0", mem_addr, 0);
    endtask

    task automatic t_moves();
        clear_img();
        code = '{8'h10, 8'h11, 8'h14, 8'h1A, 8'h33, 8'h1F, 8'h44, 8'h12, 8'h25,
                 8'h13, 8'h25, 8'h11, 8'h25, 8'h1B, 8'h12, 8'h25, 8'h10, 8'h66,
                 8'h1C, 8'h17, 8'h19, 8'h12, 8'h25, 8'h01};
        place(0);
        in_delay = 0; out_delay = 0; icount = 0;
        run("R2", 400);
        exp_q = '{8'h33, 8'h44, 8'h11, 8'h44, 8'h66};
        expect_out("R2");
        check(running == 1'b0, "R9", "running after halt opcode", running, 0);
        check(fault == 1'b0, "R9", "no fault on halt opcode", fault, 0);
    endtask

    task automatic t_alu();
        clear_img();
        code = '{8'h10, 8'h0F, 8'h30, 8'hF5, 8'h25, 8'h32, 8'h03, 8'h25, 8'h15, 8'h0A,
                 8'h31, 8'h25, 8'h34, 8'h3C, 8'h25, 8'h37, 8'h25, 8'h38, 8'h25, 8'h39,
                 8'hFF, 8'h25, 8'h3A, 8'h25, 8'h33, 8'h25, 8'h41, 8'hC8, 8'h25, 8'h40,
                 8'h25, 8'h10, 8'h05, 8'h41, 8'h03, 8'h25, 8'h35, 8'h25, 8'h36, 8'h01,
                 8'h25, 8'h01};
        place(0);
        run("R3", 800);
        exp_q = '{8'h04, 8'h0C, 8'h16, 8'h14, 8'h1E, 8'hE1, 8'h1E, 8'h14, 8'hC8,
                  8'h01, 8'h00, 8'h02, 8'h02, 8'h03};
        expect_out("R3");
    endtask

    task automatic t_jumps();
        clear_img();
        code = '{8'h10, 8'h00, 8'h03, 8'h40, 8'h05, 8'h40, 8'h04, 8'h0A, 8'h01, 8'h00,
                 8'h10, 8'h01, 8'h25, 8'h04, 8'h40, 8'h05, 8'h13, 8'h01, 8'h01, 8'h15,
                 8'h1A, 8'h08, 8'h01, 8'h01, 8'h01, 8'h01, 8'h10, 8'h02, 8'h25, 8'h0A,
                 8'h09, 8'h03, 8'h23, 8'h01, 8'h01, 8'h15, 8'h28, 8'h07, 8'h01, 8'h01,
                 8'h15, 8'h2E, 8'h10, 8'h00, 8'h09, 8'h01, 8'h15, 8'h34, 8'h06, 8'h01,
                 8'h01, 8'h01, 8'h02, 8'h38, 8'h01, 8'h01, 8'h10, 8'h03, 8'h25, 8'h01};
        place(0);
        run("R4", 1500);
        exp_q = '{8'h01, 8'h02, 8'h03};
        expect_out("R4"); // immediate jumps of all flavours
        check(fault == 1'b0, "R5", "register jumps reach the end cleanly", fault, 0);
    endtask

    task automatic t_memory();
        clear_img();
        code = '{8'h15, 8'h80, 8'h10, 8'h5A, 8'h23, 8'h10, 8'hA5, 8'h22, 8'h81,
                 8'h10, 8'h00, 8'h20, 8'h80, 8'h25, 8'h15, 8'h81, 8'h21, 8'h25, 8'h01};
        place(0);
        run("R6", 400);
        check(mem[8'h80] == 8'h5A, "R6", "store via B", mem[8'h80], 8'h5A);
        check(mem[8'h81] == 8'hA5, "R6", "store via operand", mem[8'h81], 8'hA5);
        exp_q = '{8'h5A, 8'hA5};
        expect_out("R6");
        check(both_err == 0, "R13", "read and write together", both_err, 0);
    endtask

    task automatic t_streams();
        clear_img();
        code = '{8'h24, 8'h25, 8'h24, 8'h30, 8'h01, 8'h25, 8'h01};
        place(0);
        ibuf[0] = 8'h7E; ibuf[1] = 8'h41; icount = 2;
        in_delay = 15; out_delay = 10;
        run("R7", 800);
        exp_q = '{8'h7E, 8'h42};
        expect_out("R7");
        check(iwait >= 30, "R7", "cycles waiting for input", iwait, 30);
        check(owait >= 20, "R8", "cycles waiting for acceptance", owait, 20);
        check(hold_err == 0, "R8", "offered byte held steady", hold_err, 0);
        in_delay = 0; out_delay = 0; icount = 0;
    endtask

    task automatic t_bad_opcode();
        int busy;
        clear_img();
        code = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h42};
        place(0);
        run("R10", 200);
        check(fault == 1'b1, "R10", "fault raised", fault, 1);
        check(fault_ip == 8'h04, "R10", "fault address", fault_ip, 8'h04);
        busy = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_re || mem_we || out_valid || in_ready || !halted) busy++;
        end
        check(busy == 0, "R12", "activity after stopping", busy, 0);
        clear_img();
        code = '{8'h10, 8'h07, 8'h25, 8'h3B};
        place(0);
        run("R10", 200);
        exp_q = '{8'h07};
        expect_out("R10");
        check(fault_ip == 8'h03, "R10", "fault address second case", fault_ip, 8'h03);
    endtask

    task automatic t_end_of_memory();
        clear_img();
        code = '{8'h10, 8'h3C, 8'h02, 8'hFF};
        place(0);
        img[8'hFF] = 8'h25;
        run("R11", 400);
        exp_q = '{8'h3C};
        expect_out("R11");
        check(fault == 1'b0, "R11", "no fault on one-byte overflow", fault, 0);
        clear_img();
        code = '{8'h10, 8'h3C, 8'h02, 8'hFF};
        place(0);
        img[8'hFF] = 8'h22;
        run("R11", 400);
        check(mem[8'h10] == 8'h00, "R11", "two-byte at end has no effect", mem[8'h10], 0);
        check(fault == 1'b0, "R11", "no fault on two-byte at end", fault, 0);
    endtask

    initial begin
        clear_img();
        t_reset();
        t_moves();
        t_alu();
        t_jumps();
        t_memory();
        t_streams();
        t_bad_opcode();
        t_end_of_memory();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL R12 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule